// File: doc/BRIEF.md
# Upper-Triangular Matrix Inverse Engine

This block inverts an N×N upper-triangular fixed-point matrix held in a local register file. Software or a neighbouring block fills the matrix through a simple write port, pulses `start`, and waits for `done`. The engine then builds the inverse one column at a time. It starts on the diagonal with a reciprocal. It then walks upward through the column. Each entry takes a serial multiply-accumulate over the entries already solved in that column and one serial division by the diagonal entry of its row. Entries below the diagonal are never computed, because they are known to be zero.

The result sits in an output register file that is read combinationally by row and column index. All values are two's-complement with `W` bits, of which `F` are fraction bits. A zero on the diagonal makes the matrix singular. In that case a sticky error flag is raised, and every column whose computation divided by that zero reads back as zero.

The interface has no data stream. Loading and reading are plain indexed accesses, and control is a start pulse with busy/done status, so no back-pressure exists at the edge of the block.

Top module: `utri_inv`

## Requirements
- R1: A write (`wr_en`=1) stores `wr_data` at row `wr_row`, column `wr_col` only when `wr_row` ≤ `wr_col` and `busy` is low. Writes below the diagonal, and writes made while busy, have no effect on any later result.
- R2: A `start` pulse seen while `busy` is low clears every result entry to zero, clears `err`, and raises `busy` in the next cycle. A `start` seen while `busy` is high is ignored.
- R3: Each diagonal result entry equals 2^(2F) divided by the raw diagonal entry of R, truncated toward zero. A quotient whose magnitude exceeds 2^(W-1)−1 saturates to ±(2^(W-1)−1).
- R4: For i < j, entry (i,j) equals −(Σ_{k=i+1..j} R[i][k]·Rinv[k][j]) / R[i][i]. The sum of full products is shifted right by F and saturated to W bits, and the quotient is truncated toward zero. Within a column, rows are produced from the diagonal upward.
- R5: Every result entry below the diagonal (row > column) always reads zero.
- R6: If diagonal entry z of R is zero, `err` rises and stays high until the next accepted start. Columns z through N−1 of the result read zero, and columns below z are unaffected.
- R7: `done` is high for exactly one cycle. It is first high in cycle L after the edge that samples `start`, where L = 1 + Σ_{j=0..N-1} [(W+3) + Σ_{i<j} (j−i+W+2)]. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the input matrix |
| wr_row | input | clog2(N) | Row index of the write |
| wr_col | input | clog2(N) | Column index of the write |
| wr_data | input | W | Signed fixed-point entry to store |
| start | input | 1 | Begin an inversion |
| busy | output | 1 | Inversion in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky zero-diagonal flag |
| rd_row | input | clog2(N) | Row index of the result read |
| rd_col | input | clog2(N) | Column index of the result read |
| rd_data | output | W | Signed result entry at (rd_row, rd_col) |

## Verification
Nothing in the result is final until `done`, and `done` is due exactly L cycles after the start edge: W+3 cycles for each diagonal reciprocal with its column close, plus j−i+W+2 cycles for each entry above the diagonal. The bench counts falling edges from the sampling edge and requires `done` to appear at that count, neither earlier nor later. It reads the result file only after that point. The read port is combinational, so each read is sampled one step after its indices are driven. The error flag is checked right after completion and again twenty idle cycles later to confirm that it holds.

// File: rtl/utri_pkg.sv
package utri_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIAG,
    ST_DIV,
    ST_MAC,
    ST_ODIV,
    ST_CEND,
    ST_DONE
  } utri_state_e;
endpackage

// File: rtl/utri_div.sv
// Serial restoring divider: quotient = (num << F) / den, truncated toward zero,
// one quotient bit per cycle over W cycles, saturated to W-bit signed range.
module utri_div #(
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic signed [W-1:0] num,
  input  logic                neg,
  input  logic signed [W-1:0] den,
  output logic                done,
  output logic signed [W-1:0] quo
);
  localparam int CW = $clog2(W);

  function automatic logic [W-1:0] mag(input logic signed [W-1:0] x);
    return x[W-1] ? W'(-x) : W'(x);
  endfunction

  logic          run, sgn, ovf;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rem, dvd, qacc, dmag, nmag, dmag_in, top_bits, msat;
  logic [W:0]    rem2;
  logic          ge;

  assign nmag     = mag(num);
  assign dmag_in  = mag(den);
  assign top_bits = {{(W-F){1'b0}}, nmag[W-1 -: F]};
  assign rem2     = {rem, dvd[W-1]};
  assign ge       = rem2 >= {1'b0, dmag};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      dvd  <= '0;
      qacc <= '0;
      dmag <= '0;
      sgn  <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run  <= 1'b1;
        cnt  <= '0;
        rem  <= top_bits;
        dvd  <= nmag << F;
        qacc <= '0;
        dmag <= dmag_in;
        sgn  <= num[W-1] ^ den[W-1] ^ neg;
        ovf  <= top_bits >= dmag_in;
      end else if (run) begin
        rem  <= ge ? W'(rem2 - {1'b0, dmag}) : W'(rem2);
        dvd  <= dvd << 1;
        qacc <= {qacc[W-2:0], ge};
        if (cnt == CW'(W-1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign msat = (ovf || qacc[W-1]) ? {1'b0, {(W-1){1'b1}}} : qacc;
  assign quo  = sgn ? -$signed(msat) : $signed(msat);
endmodule

// File: rtl/utri_mac.sv
// Signed multiply-accumulate with synchronous clear, one product per cycle.
module utri_mac #(
  parameter int W  = 16,
  parameter int AW = 35
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  output logic signed [AW-1:0] acc
);
  logic signed [2*W-1:0] prod;
  assign prod = a * b;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc + {{(AW-2*W){prod[2*W-1]}}, prod};
  end
endmodule

// File: rtl/utri_inv.sv
module utri_inv
  import utri_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 16,
  parameter int F = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IW-1:0]       wr_row,
  input  logic [IW-1:0]       wr_col,
  input  logic signed [W-1:0] wr_data,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic                err,
  input  logic [IW-1:0]       rd_row,
  input  logic [IW-1:0]       rd_col,
  output logic signed [W-1:0] rd_data
);
  localparam int AW = 2*W + IW + 1;
  localparam logic [IW-1:0] LAST = IW'(N-1);
  localparam logic signed [W-1:0]  ONE  = W'(64'd1 << F);
  localparam logic signed [AW-1:0] SMAX = AW'((64'd1 << (W-1)) - 64'd1);
  localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

  logic signed [W-1:0] rmat [N][N];
  logic signed [W-1:0] rinv [N][N];

  utri_state_e   state;
  logic [IW-1:0] col, row, k;
  logic          col_bad, dz, accept;

  // Input matrix: only the upper triangle is ever stored
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) rmat[r][c] <= '0;
    end else if (wr_en && !busy && wr_row <= wr_col && wr_col <= LAST) begin
      rmat[wr_row][wr_col] <= wr_data;
    end
  end

  // Accumulator for the off-diagonal sums
  logic signed [AW-1:0] acc, acc_sh;
  logic signed [W-1:0]  acc_sat;

  utri_mac #(.W(W), .AW(AW)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .clr(state == ST_DIV), .en(state == ST_MAC),
    .a(rmat[row][k]), .b(rinv[k][col]), .acc(acc)
  );

  always_comb begin
    acc_sh = acc >>> F;
    if (acc_sh > SMAX)      acc_sat = SMAX[W-1:0];
    else if (acc_sh < SMIN) acc_sat = SMIN[W-1:0];
    else                    acc_sat = acc_sh[W-1:0];
  end

  // Shared serial divider: reciprocal on the diagonal, quotient above it
  logic                div_go, div_done;
  logic signed [W-1:0] div_num, div_q;

  assign div_go  = (state == ST_DIAG) || (state == ST_ODIV);
  assign div_num = (state == ST_DIAG) ? ONE : acc_sat;

  utri_div #(.W(W), .F(F)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num),
    .neg(state == ST_ODIV), .den(rmat[row][row]),
    .done(div_done), .quo(div_q)
  );

  assign accept = start && (state == ST_IDLE || state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      col     <= '0;
      row     <= '0;
      k       <= '0;
      err     <= 1'b0;
      col_bad <= 1'b0;
      dz      <= 1'b0;
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) rinv[r][c] <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            for (int r = 0; r < N; r++)
              for (int c = 0; c < N; c++) rinv[r][c] <= '0;
            err     <= 1'b0;
            col_bad <= 1'b0;
            col     <= '0;
            row     <= '0;
            state   <= ST_DIAG;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_DIAG, ST_ODIV: begin
          dz    <= (rmat[row][row] == '0);
          state <= ST_DIV;
        end
        ST_DIV: begin
          if (div_done) begin
            rinv[row][col] <= dz ? '0 : div_q;
            if (dz) begin
              err     <= 1'b1;
              col_bad <= 1'b1;
            end
            if (row == '0) begin
              state <= ST_CEND;
            end else begin
              row   <= row - IW'(1);
              k     <= row;
              state <= ST_MAC;
            end
          end
        end
        ST_MAC: begin
          if (k == col) state <= ST_ODIV;
          else          k     <= k + IW'(1);
        end
        ST_CEND: begin
          if (col_bad)
            for (int r = 0; r < N; r++) rinv[r][col] <= '0;
          col_bad <= 1'b0;
          if (col == LAST) begin
            state <= ST_DONE;
          end else begin
            col   <= col + IW'(1);
            row   <= col + IW'(1);
            state <= ST_DIAG;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy    = (state != ST_IDLE) && (state != ST_DONE);
  assign done    = (state == ST_DONE);
  assign rd_data = rinv[rd_row][rd_col];
endmodule

// File: rtl/utri_inv_chk.sv
module utri_inv_chk #(
  parameter int N = 4,
  parameter int W = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                busy,
  input logic                done,
  input logic                err,
  input logic [IW-1:0]       rd_row,
  input logic [IW-1:0]       rd_col,
  input logic signed [W-1:0] rd_data
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(busy) && !busy));

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !err));

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(start && !busy)) |=> err);

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(start && !busy));

  // R5
  lower_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_row > rd_col) |-> (rd_data == '0));
endmodule

bind utri_inv utri_inv_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
);

// File: tb/test_utri_inv.sv
`timescale 1ns/1ps
module test_utri_inv;
  localparam int N = 4;
  localparam int W = 16;
  localparam int F = 8;
  localparam int IW = 2;
  localparam real SC = 256.0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_row = '0, wr_col = '0, rd_row = '0, rd_col = '0;
  logic signed [W-1:0] wr_data = '0;
  logic start = 1'b0;
  logic busy, done, err;
  logic signed [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int rm  [N][N];
  int got [N][N];
  real rf [N][N];
  int lat_exp;

  always #2.5 clk = ~clk;

  utri_inv #(.N(N), .W(W), .F(F)) i_utri_inv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .start(start), .busy(busy), .done(done), .err(err),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load_upper();
    for (int i = 0; i < N; i++)
      for (int j = i; j < N; j++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_row = IW'(i); wr_col = IW'(j); wr_data = W'(rm[i][j]);
      end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int poke, output int lat);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 1;
    while (!done && n < 5000) begin
      if (n == poke) begin
        wr_en = 1'b1; wr_row = '0; wr_col = '0; wr_data = 16'sd7; start = 1'b1;
      end else begin
        wr_en = 1'b0; start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    wr_en = 1'b0; start = 1'b0;
    lat = n;
  endtask

  task automatic read_all();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd_row = IW'(i); rd_col = IW'(j);
        #0.5;
        got[i][j] = int'(rd_data);
      end
  endtask

  // real-valued reference inverse of the upper triangle of rm
  task automatic ref_inv();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) rf[i][j] = 0.0;
    for (int j = 0; j < N; j++) begin
      rf[j][j] = SC / real'(rm[j][j]);
      for (int i = j - 1; i >= 0; i--) begin
        real s = 0.0;
        for (int k = i + 1; k <= j; k++) s += (real'(rm[i][k]) / SC) * rf[k][j];
        rf[i][j] = -s / (real'(rm[i][i]) / SC);
      end
    end
  endtask

  function automatic int recip(input int r);
    int m;
    m = 65536 / (r < 0 ? -r : r);
    if (m > 32767) m = 32767;
    return (r < 0) ? -m : m;
  endfunction

  task automatic set_dense();
    foreach (rm[i, j]) rm[i][j] = 0;
    rm[0][0] = 512;  rm[0][1] = 128; rm[0][2] = -64;  rm[0][3] = 256;
    rm[1][1] = -256; rm[1][2] = 192; rm[1][3] = -128;
    rm[2][2] = 128;  rm[2][3] = 64;
    rm[3][3] = 1024;
  endtask

  task automatic cmp_ref(input int cmax, input string tag);
    for (int i = 0; i < N; i++)
      for (int j = i; j <= cmax; j++) begin
        int e = $rtoi(rf[i][j] * SC);
        int d = got[i][j] - e;
        check(d <= 6 && d >= -6, tag, got[i][j], e);
      end
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R2 reset busy", int'(busy), 0);
    check(done == 1'b0, "R7 reset done", int'(done), 0);
    check(err == 1'b0, "R6 reset err", int'(err), 0);
    read_all();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) check(got[i][j] == 0, "R2 reset result", got[i][j], 0);
  endtask

  task automatic t_diag();
    int lat;
    foreach (rm[i, j]) rm[i][j] = 0;
    rm[0][0] = 256; rm[1][1] = 512; rm[2][2] = -1024; rm[3][3] = 64;
    load_upper();
    run(0, lat);
    check(lat == lat_exp, "R7 latency diag", lat, lat_exp);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", int'(done), 0);
    read_all();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i == j) check(got[i][i] == recip(rm[i][i]), "R3 reciprocal", got[i][i], recip(rm[i][i]));
        else        check(got[i][j] == 0, "R4 zero off-diagonal", got[i][j], 0);
  endtask

  task automatic t_sat();
    int lat;
    foreach (rm[i, j]) rm[i][j] = 0;
    rm[0][0] = 1; rm[1][1] = -1; rm[2][2] = 192; rm[3][3] = 256;
    load_upper();
    run(0, lat);
    read_all();
    for (int i = 0; i < N; i++)
      check(got[i][i] == recip(rm[i][i]), "R3 saturation/truncation", got[i][i], recip(rm[i][i]));
    check(err == 1'b0, "R6 no err", int'(err), 0);
  endtask

  task automatic t_dense();
    int lat;
    set_dense();
    load_upper();
    run(0, lat);
    check(lat == lat_exp, "R7 latency dense", lat, lat_exp);
    check(busy == 1'b0, "R7 busy low at done", int'(busy), 0);
    read_all();
    ref_inv();
    cmp_ref(N - 1, "R4 dense entry");
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        real s = 0.0;
        real idv = (i == j) ? 1.0 : 0.0;
        int sm;
        for (int k = i; k < N; k++) s += (real'(rm[i][k]) / SC) * (real'(got[k][j]) / SC);
        sm = $rtoi(s * 1000.0);
        check(s - idv < 0.08 && idv - s < 0.08, "R4 R*Rinv identity (x1000)", sm, $rtoi(idv * 1000.0));
        if (i > j) check(got[i][j] == 0, "R5 below diagonal", got[i][j], 0);
      end
  endtask

  task automatic t_ignore();
    int lat;
    set_dense();
    load_upper();
    // R1: writes below the diagonal must not reach the computation
    for (int i = 1; i < N; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_row = IW'(i); wr_col = IW'(i - 1); wr_data = 16'sd1000;
    end
    @(negedge clk); wr_en = 1'b0;
    // R2: restart and write during busy must both be ignored
    run(10, lat);
    check(lat == lat_exp, "R2 start while busy ignored", lat, lat_exp);
    read_all();
    ref_inv();
    cmp_ref(N - 1, "R1 lower/busy writes ignored");
    run(0, lat);
    read_all();
    check(got[0][0] == recip(rm[0][0]), "R1 busy write to R00 dropped", got[0][0], recip(rm[0][0]));
    for (int i = 1; i < N; i++) check(got[i][i - 1] == 0, "R5 lower entry", got[i][i - 1], 0);
  endtask

  task automatic t_zero();
    int lat;
    set_dense();
    rm[2][2] = 0;
    load_upper();
    run(0, lat);
    check(err == 1'b1, "R6 err raised", int'(err), 1);
    read_all();
    for (int i = 0; i < N; i++)
      for (int j = 2; j < N; j++) check(got[i][j] == 0, "R6 singular column zero", got[i][j], 0);
    ref_inv();
    cmp_ref(1, "R6 earlier column intact");
    repeat (20) @(negedge clk);
    check(err == 1'b1, "R6 err sticky", int'(err), 1);
    rm[2][2] = 128;
    load_upper();
    run(0, lat);
    check(err == 1'b0, "R6 err cleared by start", int'(err), 0);
    read_all();
    ref_inv();
    cmp_ref(N - 1, "R6 recovery result");
  endtask

  initial begin
    lat_exp = 1;
    for (int j = 0; j < N; j++) begin
      lat_exp += W + 3;
      for (int i = 0; i < j; i++) lat_exp += j - i + W + 2;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_diag();
    t_sat();
    t_dense();
    t_ignore();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R7 watchdog: got no completion expected done within limit");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule